// File: doc/BRIEF.md
# Register-Pair Unsigned Divider

This block is a multi-cycle unsigned divider whose operands and results are laid out as 16-bit register halves. In narrow mode it divides the half `ax_in` by the half `de_in`. The quotient comes back on `ax_out` and the remainder on `de_out`. In wide mode the dividend is the 32-bit value `{bc_in, ax_in}` and the divisor is `{hl_in, de_in}`, with the first-named half as the upper half in each pair. The quotient returns on `{bc_out, ax_out}` and the remainder on `{hl_out, de_out}`.

A one-cycle `start` pulse latches the operands and the mode. The block then runs a restoring shift-subtract loop that resolves two quotient bits per clock. This gives a fixed latency of 9 cycles in narrow mode and 17 cycles in wide mode. A zero divisor raises no error. It produces an all-ones quotient and returns the dividend as the remainder, and it takes the same latency as any other divide.

The controller has three states. IDLE waits for work. RUN performs two restoring steps per cycle while a pair counter counts down. FINISH lasts one cycle and raises `done`. The transitions are:

- IDLE to RUN on `start`.
- RUN to RUN while more than one bit pair remains.
- RUN to FINISH on the last bit pair.
- FINISH to RUN on `start`.
- FINISH to IDLE otherwise.

Top module: `regpair_divider`

## Requirements
- R1: In narrow mode (`wide`=0), the result holds `ax_out` = `ax_in`/`de_in` and `de_out` = `ax_in` mod `de_in`, with `bc_out` and `hl_out` both 0.
- R2: In wide mode (`wide`=1), the result holds {`bc_out`,`ax_out`} = {`bc_in`,`ax_in`} / {`hl_in`,`de_in`} and {`hl_out`,`de_out`} = the remainder, with the first-named half as bits 31:16 of each pair.
- R3: In narrow mode, a zero divisor gives `ax_out`=16'hFFFF, `de_out`=`ax_in`, and `bc_out`=`hl_out`=0.
- R4: In wide mode, a zero divisor gives `bc_out`=`ax_out`=16'hFFFF and {`hl_out`,`de_out`} equal to the full 32-bit dividend.
- R5: In narrow mode, if `start` is high in cycle c0, `done` is high in cycle c9 and not earlier. `busy` is high from c1 until the cycle before `done`.
- R6: In wide mode, if `start` is high in cycle c0, `done` is high in cycle c17 and not earlier. `busy` is high from c1 until the cycle before `done`.
- R7: `done` is a single-cycle pulse with `busy` low. A `start` in the `done` cycle is accepted and begins a new divide.
- R8: A `start` while `busy` is high is ignored, and so are operand changes during that time. The running divide finishes on time with the results of the originally latched operands.
- R9: After `done`, the result outputs stay constant until the next accepted `start`, whatever the inputs do.
- R10: While `rst_n` is low, `busy` and `done` are 0 and all four result halves are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a divide; sampled only when not busy |
| wide | input | 1 | 0 = 16-bit divide, 1 = 32-bit divide |
| ax_in | input | 16 | Dividend low half (whole dividend in narrow mode) |
| bc_in | input | 16 | Dividend high half (wide mode) |
| de_in | input | 16 | Divisor low half (whole divisor in narrow mode) |
| hl_in | input | 16 | Divisor high half (wide mode) |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle pulse: results valid |
| ax_out | output | 16 | Quotient low half |
| bc_out | output | 16 | Quotient high half (0 in narrow mode) |
| de_out | output | 16 | Remainder low half |
| hl_out | output | 16 | Remainder high half (0 in narrow mode) |

## Verification
The bench sweeps both modes over cross products of boundary operands and a run of pseudo-random operands, and predicts each result with plain division. The boundary operands include 0, 1, all-ones, the top-bit-only value and values just past the 16-bit range. A zero divisor that the design special-cased wrongly would show up as a wrong quotient or a truncated remainder. A narrow divide that left dividend bits in the upper halves would show nonzero `bc_out` or `hl_out`. A pair counter loaded with the wrong count would move `done` off cycle 9 or 17. Further runs pulse `start` mid-divide, start again in the `done` cycle and wiggle the inputs after completion. A design that re-latched operands, dropped a back-to-back request or let its results drift would fail these.

// File: rtl/regpair_div_pkg.sv
package regpair_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } div_state_e;
endpackage

// File: rtl/regpair_div_step.sv
// One restoring shift-subtract step: shift the next dividend bit into the
// partial remainder, subtract the divisor if it fits, record the bit.
module regpair_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        trial   = shifted - {1'b0, dvs_i};
        fits    = ~trial[W];
        rem_o   = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/regpair_div_ctrl.sv
module regpair_div_ctrl
    import regpair_div_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int BPC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wide,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);
    localparam int FULL_W      = 2 * HALF_W;
    localparam int PAIRS_WIDE  = FULL_W / BPC;
    localparam int PAIRS_NARR  = HALF_W / BPC;
    localparam int CNT_W       = $clog2(PAIRS_WIDE + 1);

    div_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remaining bit-pair counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= wide ? CNT_W'(PAIRS_WIDE) : CNT_W'(PAIRS_NARR);
        else if (step_en) cnt_q <= cnt_q - CNT_W'(1);
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                busy    = 1'b1;
                step_en = 1'b1;
                if (cnt_q == CNT_W'(1)) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done = 1'b1;
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R8: a start seen while busy does not reload the counter
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt_q > CNT_W'(1)) |=> (busy && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R7: done lasts exactly one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5/R6: done is only reached from a running divide
    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R7: busy and done never overlap
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));
endmodule

// File: rtl/regpair_divider.sv
module regpair_divider #(
    parameter int HALF_W = 16,
    parameter int BPC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [HALF_W-1:0] ax_in,
    input  logic [HALF_W-1:0] bc_in,
    input  logic [HALF_W-1:0] de_in,
    input  logic [HALF_W-1:0] hl_in,
    output logic              busy,
    output logic              done,
    output logic [HALF_W-1:0] ax_out,
    output logic [HALF_W-1:0] bc_out,
    output logic [HALF_W-1:0] de_out,
    output logic [HALF_W-1:0] hl_out
);
    localparam int FULL_W = 2 * HALF_W;

    logic              load, step_en;
    logic [FULL_W-1:0] rem_q, quo_q, dvs_q;
    logic              wide_q;
    logic [FULL_W-1:0] rem_c [0:BPC];
    logic [FULL_W-1:0] quo_c [0:BPC];

    regpair_div_ctrl #(.HALF_W(HALF_W), .BPC(BPC)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wide    (wide),
        .load    (load),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    assign rem_c[0] = rem_q;
    assign quo_c[0] = quo_q;

    generate
        for (genvar s = 0; s < BPC; s++) begin : g_step
            regpair_div_step #(.W(FULL_W)) u_step (
                .rem_i (rem_c[s]),
                .quo_i (quo_c[s]),
                .dvs_i (dvs_q),
                .rem_o (rem_c[s+1]),
                .quo_o (quo_c[s+1])
            );
        end
    endgenerate

    // Narrow mode parks the dividend in the upper half so that its bits are
    // consumed first; the vacated low half collects the quotient.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= wide ? {bc_in, ax_in} : {ax_in, {HALF_W{1'b0}}};
            dvs_q  <= wide ? {hl_in, de_in} : {{HALF_W{1'b0}}, de_in};
            wide_q <= wide;
        end else if (step_en) begin
            rem_q  <= rem_c[BPC];
            quo_q  <= quo_c[BPC];
        end
    end

    assign ax_out = quo_q[HALF_W-1:0];
    assign bc_out = quo_q[FULL_W-1:HALF_W];
    assign de_out = rem_q[HALF_W-1:0];
    assign hl_out = rem_q[FULL_W-1:HALF_W];

    // R8: latched divisor is untouched for the whole run
    assert_divisor_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dvs_q));

    // R3: narrow divide by zero yields an all-ones quotient half
    assert_zero_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q && dvs_q == '0) |-> (ax_out == {HALF_W{1'b1}} && bc_out == '0));

    // R4: wide divide by zero yields an all-ones quotient
    assert_zero_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wide_q && dvs_q == '0) |-> ({bc_out, ax_out} == {FULL_W{1'b1}}));

    // R1: narrow results never spill into the upper halves
    assert_narrow_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (hl_out == '0 && bc_out == '0));

    // R9: results frozen while idle
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(load) && !$past(step_en)) |-> ($stable(quo_q) && $stable(rem_q)));
endmodule

// File: tb/regpair_divider_bench.sv
module regpair_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] ax_in = '0, bc_in = '0, de_in = '0, hl_in = '0;
    logic        busy, done;
    logic [15:0] ax_out, bc_out, de_out, hl_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q, exp_r;
    logic [31:0] lcg = 32'h1ACE_0F17;

    always #10 clk = ~clk;

    regpair_divider u_regpair_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
        .ax_in(ax_in), .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in),
        .busy(busy), .done(done),
        .ax_out(ax_out), .bc_out(bc_out), .de_out(de_out), .hl_out(hl_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    task automatic do_op(input bit w, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] d, input logic [15:0] h,
                         input bit now, input bit poke);
        logic [31:0] dvd, dvs;
        int lat;
        string rq, rl;
        dvd = w ? {b, a} : {16'h0, a};
        dvs = w ? {h, d} : {16'h0, d};
        if (dvs == 0) begin
            exp_q = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            exp_r = dvd;
        end else begin
            exp_q = dvd / dvs;
            exp_r = dvd % dvs;
        end
        rq = w ? ((dvs == 0) ? "R4" : "R2") : ((dvs == 0) ? "R3" : "R1");
        rl = w ? "R6" : "R5";
        if (!now) @(negedge clk);
        wide = w; ax_in = a; bc_in = b; de_in = d; hl_in = h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, rl, "busy in c1", busy, 1);
        lat = 1;
        while (!done && lat < 40) begin
            if (poke && lat == 3) begin
                start = 1'b1; wide = ~w;
                ax_in = ~a; bc_in = ~b; de_in = d + 16'd3; hl_in = ~h;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check(lat == (w ? 17 : 9), poke ? "R8" : rl, "latency", lat, w ? 17 : 9);
        check(busy == 1'b0, "R7", "busy low at done", busy, 0);
        check({bc_out, ax_out} == exp_q, poke ? "R8" : rq, "quotient", {bc_out, ax_out}, exp_q);
        check({hl_out, de_out} == exp_r, poke ? "R8" : rq, "remainder", {hl_out, de_out}, exp_r);
    endtask

    logic [15:0] e16 [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h00FF, 16'h0100,
                              16'h1234, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF, 16'h03E8};
    logic [31:0] e32 [12] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h0000_FFFF, 32'h0001_0000,
                              32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFE, 32'hFFFF_FFFF,
                              32'h1234_5678, 32'h00AB_CDEF};

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 0 && done == 0, "R10", "busy/done in reset", {busy, done}, 0);
        check({ax_out, bc_out, de_out, hl_out} == 64'h0, "R10", "results in reset",
              {ax_out, bc_out, de_out, hl_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R3/R5: narrow boundary sweep
        foreach (e16[i]) foreach (e16[j]) do_op(1'b0, e16[i], 16'hA5A5, e16[j], 16'h5A5A, 0, 0);
        // R2/R4/R6: wide boundary sweep
        foreach (e32[i]) foreach (e32[j])
            do_op(1'b1, e32[i][15:0], e32[i][31:16], e32[j][15:0], e32[j][31:16], 0, 0);
        // Mixed pseudo-random operands, both modes
        for (int k = 0; k < 300; k++) begin
            logic [31:0] x, y;
            x = rnd();
            y = rnd();
            if (k % 3 == 0) y = y >> (y[4:0]);
            do_op(k[0], x[15:0], x[31:16], y[15:0], y[31:16], 0, 0);
        end

        // R8: start mid-run is ignored
        do_op(1'b0, 16'd50000, 16'h0, 16'd7, 16'h0, 0, 1);
        do_op(1'b1, 16'h4321, 16'hDEAD, 16'h0101, 16'h0002, 0, 1);

        // R7: start in the done cycle, then a one-cycle pulse
        do_op(1'b0, 16'd1000, 16'h0, 16'd33, 16'h0, 0, 0);
        do_op(1'b1, 16'hFFFF, 16'hFFFF, 16'h0010, 16'h0000, 1, 0);
        do_op(1'b0, 16'd9, 16'h0, 16'd0, 16'h0, 1, 0);
        @(negedge clk);
        check(done == 1'b0, "R7", "done after pulse", done, 0);

        // R9: results hold while inputs change
        do_op(1'b1, 16'h9ABC, 16'h1357, 16'h00F0, 16'h0000, 0, 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ax_in = rnd(); bc_in = rnd(); de_in = rnd(); hl_in = rnd(); wide = k[0];
        end
        check({bc_out, ax_out} == exp_q, "R9", "held quotient", {bc_out, ax_out}, exp_q);
        check({hl_out, de_out} == exp_r, "R9", "held remainder", {hl_out, de_out}, exp_r);
        check(busy == 0 && done == 0, "R9", "idle after hold", {busy, done}, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule